// File: doc/BRIEF.md
# Round-Robin Bus Ownership Arbiter

This block decides which of several bus masters may drive a shared, multiplexed bus. Each master has its own private request input and its own private grant output. Nothing is shared between masters. Every decision is made on the bus clock. The current owner signals that a transfer is under way with a bus-busy input, and it flags the final data cycle of that transfer.

The next owner is chosen during the final data cycle of the running transfer. The new grant is therefore visible in the very next cycle, and ownership changes hands without a dead cycle spent arbitrating. Competing requesters are served in rotation, starting after the present owner. An owner that holds a grant on an idle bus but never starts a transfer loses the grant after a configurable number of cycles. When nobody asks for the bus, the grant stays parked on the last owner.

Top module: `bus_grant_arbiter`

## Requirements
- R1: During and right after reset the grant is parked on master 0. Bit i of `gnt_o` and of `req_i` belongs to master i, so `gnt_o` reads 0001 with four masters.
- R2: Exactly one bit of `gnt_o` is set in every cycle.
- R3: While `bus_busy_i` is high and `last_beat_i` is low, `gnt_o` does not change in the following cycle.
- R4: When `bus_busy_i` and `last_beat_i` are both high and at least one master requests, the grant in the next cycle goes to the rotation winner. The winner is the first requesting master found by searching upward in index from the current owner plus one, wrapping around, with the current owner tried last.
- R5: When the bus is idle (`bus_busy_i` low) and the current owner is not requesting, the grant moves in the next cycle to the rotation winner among the requesters.
- R6: When the owner requests on an idle bus for `IDLE_LIMIT` consecutive cycles, the grant moves to the rotation winner at the clock edge that ends the last of those cycles. The count restarts whenever the bus is busy, the owner drops its request, or the grant moves.
- R7: When no master requests, the grant does not change.
- R8: An owner that requests on an idle bus and has not yet used up `IDLE_LIMIT` cycles keeps the grant, even while other masters request.
- R9: Whenever the grant changes, the new owner was requesting in the cycle before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Per-master request lines, bit i for master i |
| bus_busy_i | input | 1 | The current owner is in a transfer this cycle |
| last_beat_i | input | 1 | This is the owner's final data cycle (meaningful while busy) |
| gnt_o | output | N_MASTERS | Per-master grant lines, exactly one set |

## Verification
The arbiter's only internal state is the owner index and an idle counter. A wrong owner index shows up on `gnt_o` in the same cycle, either as the wrong bit or as a broken one-hot pattern. A wrong counter only becomes visible when the owner keeps requesting on an idle bus. In that case the grant moves one or more cycles too early or too late compared with the `IDLE_LIMIT` boundary. An error in the rotation order appears at the first handover where several masters compete, one cycle after the last beat.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // Why the grant is allowed to move in this cycle
    typedef enum logic [1:0] {
        MV_NONE      = 2'd0,
        MV_LAST_BEAT = 2'd1,
        MV_RELEASE   = 2'd2,
        MV_TIMEOUT   = 2'd3
    } move_cause_e;

    // Decide whether the current cycle opens a window for re-arbitration
    function automatic move_cause_e classify_cycle(
        input logic busy,
        input logic last_beat,
        input logic holder_req,
        input logic expired
    );
        move_cause_e cause;
        if (busy)
            cause = last_beat ? MV_LAST_BEAT : MV_NONE;
        else if (!holder_req)
            cause = MV_RELEASE;
        else if (expired)
            cause = MV_TIMEOUT;
        else
            cause = MV_NONE;
        return cause;
    endfunction

endpackage

// File: rtl/bus_arb_rr_pick.sv
module bus_arb_rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int IW = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IW-1:0]        ptr,
    output logic                 found,
    output logic [IW-1:0]        pick
);

    localparam logic [IW:0] N_WIDE = (IW+1)'(N_MASTERS);

    // Search from ptr+1 upward, wrapping, with ptr itself tried last
    always_comb begin
        found = 1'b0;
        pick  = ptr;
        for (int k = 1; k <= N_MASTERS; k++) begin
            logic [IW:0] pos;
            pos = {1'b0, ptr} + (IW+1)'(k);
            if (pos >= N_WIDE)
                pos = pos - N_WIDE;
            if (!found && req[pos[IW-1:0]]) begin
                found = 1'b1;
                pick  = pos[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/bus_arb_idle_timer.sv
module bus_arb_idle_timer #(
    parameter int IDLE_LIMIT = 8,
    localparam int CW = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic expire
);

    localparam logic [CW-1:0] LAST_TICK = CW'(IDLE_LIMIT - 1);

    logic [CW-1:0] idle_cnt;

    assign expire = tick && (idle_cnt == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst || clear || !tick)
            idle_cnt <= '0;
        else
            idle_cnt <= idle_cnt + 1'b1;
    end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import bus_arb_pkg::*;
#(
    parameter int N_MASTERS  = 4,
    parameter int IDLE_LIMIT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 bus_busy_i,
    input  logic                 last_beat_i,
    output logic [N_MASTERS-1:0] gnt_o
);

    localparam int IW = $clog2(N_MASTERS);

    logic [IW-1:0] owner_q;
    logic [IW-1:0] winner;
    logic          winner_ok;
    logic          holder_req;
    logic          idle_tick;
    logic          timed_out;
    logic          move;
    move_cause_e   cause;

    assign holder_req = req_i[owner_q];
    assign idle_tick  = !bus_busy_i && holder_req;

    bus_arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req   (req_i),
        .ptr   (owner_q),
        .found (winner_ok),
        .pick  (winner)
    );

    bus_arb_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (idle_tick),
        .clear  (move),
        .expire (timed_out)
    );

    always_comb begin
        cause = classify_cycle(bus_busy_i, last_beat_i, holder_req, timed_out);
        move  = (cause != MV_NONE) && winner_ok;
    end

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= '0;
        else if (move)
            owner_q <= winner;
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
        assign gnt_o[g] = (owner_q == IW'(g));
    end

endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk #(
    parameter int N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req_i,
    input logic                 bus_busy_i,
    input logic                 last_beat_i,
    input logic [N_MASTERS-1:0] gnt_o
);

    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot(gnt_o));

    a_r3_hold_in_transfer: assert property (@(posedge clk) disable iff (rst)
        (bus_busy_i && !last_beat_i) |=> $stable(gnt_o));

    a_r4_handover_on_last: assert property (@(posedge clk) disable iff (rst)
        (bus_busy_i && last_beat_i && ((req_i & ~gnt_o) != '0))
            |=> (gnt_o != $past(gnt_o)));

    a_r7_park_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> $stable(gnt_o));

    a_r9_move_to_requester: assert property (@(posedge clk) disable iff (rst)
        !$stable(gnt_o) |-> (($past(req_i) & gnt_o) != '0));

endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .bus_busy_i  (bus_busy_i),
    .last_beat_i (last_beat_i),
    .gnt_o       (gnt_o)
);

// File: tb/bus_grant_arbiter_bench.sv
module bus_grant_arbiter_bench;

    localparam int N   = 4;
    localparam int LIM = 5;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic         busy;
    logic         last;
    logic [N-1:0] gnt;

    int n_cmp = 0;
    int n_bad = 0;
    int own_m = 0;
    int cnt_m = 0;

    always #5 clk = ~clk;

    bus_grant_arbiter #(.N_MASTERS(N), .IDLE_LIMIT(LIM)) u_bus_grant_arbiter (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .bus_busy_i  (busy),
        .last_beat_i (last),
        .gnt_o       (gnt)
    );

    // Rotation winner: first requester after cur, cur itself last; -1 if none
    function automatic int rr_next(input logic [N-1:0] r, input int cur);
        for (int k = 1; k <= N; k++) begin
            int idx = (cur + k) % N;
            if (r[idx]) return idx;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] onehot_of(input int idx);
        return (N)'(1 << idx);
    endfunction

    task automatic compare(input logic [N-1:0] exp, input string tag);
        n_cmp++;
        if (gnt !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected %b at %0t", tag, gnt, exp, $time);
        end
        n_cmp++;
        if ($countones(gnt) != 1) begin
            n_bad++;
            $display("FAIL R2 (%s): gnt=%b has %0d bits set, expected 1",
                     tag, gnt, $countones(gnt));
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic b, input logic l,
                        input string tag);
        int  w;
        bit  tick;
        bit  mv;
        req  = r;
        busy = b;
        last = l;
        w    = rr_next(r, own_m);
        tick = !b && r[own_m];
        mv   = (w >= 0) && (b ? l : (!r[own_m] || (tick && cnt_m == LIM - 1)));
        cnt_m = (mv || !tick) ? 0 : cnt_m + 1;
        if (mv) own_m = w;
        @(posedge clk);
        #1;
        compare(onehot_of(own_m), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int left;
        void'($urandom(32'd2024));
        rst = 1'b1; req = '0; busy = 1'b0; last = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare(4'b0001, "R1 in reset");
        rst = 1'b0;
        @(posedge clk);
        #1;
        compare(4'b0001, "R1 after reset");

        // R7: quiet bus keeps the parked owner
        repeat (3) step(4'b0000, 1'b0, 1'b0, "R7");
        // R5: owner 0 not requesting, master 2 asks
        step(4'b0100, 1'b0, 1'b0, "R5");
        step(4'b0100, 1'b0, 1'b0, "R8");
        // R6/R8: owner 2 requests on idle bus while master 0 waits
        repeat (LIM + 1) step(4'b0101, 1'b0, 1'b0, "R6/R8");
        // R3 and R4: transfer by owner, competitor waits, hidden handover
        step(4'b0001, 1'b1, 1'b0, "R3");
        step(4'b0011, 1'b1, 1'b0, "R3");
        step(4'b0011, 1'b1, 1'b1, "R4");
        step(4'b0010, 1'b1, 1'b0, "R4");
        // R4: full rotation with everyone requesting
        repeat (5) step(4'b1111, 1'b1, 1'b1, "R4");
        // R4: only the owner requests on the last beat, it keeps the grant
        step(onehot_of(own_m), 1'b1, 1'b1, "R4");

        // Random traffic with a transfer model driven by the expected owner
        left = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] r;
            r = ($urandom % 4 == 0) ? '0 : (N)'($urandom);
            if (left == 0 && r[own_m] && ($urandom % 2 == 0))
                left = 1 + int'($urandom % 4);
            step(r, left > 0, left == 1, "R3/R4/R5/R6/R8/R9 random");
            if (left > 0) left--;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule